// File: doc/BRIEF.md
# ADC Control and Conversion Sequencer

This block is the digital controller for a multi-channel analog-to-digital converter. Software reaches it through a simple 32-bit register interface with separate write and read strobes. It selects a channel and a reference, times a conversion with a programmable prescaler, and scales the sampled value against the chosen reference into a 10-bit code that saturates at full scale. It can also raise a level interrupt when a conversion finishes.

The analog front end is not part of the block. Each channel's sample and both reference values arrive as unsigned digital words on input ports. A conversion is started by a control write that sets the convert bit. The busy bit reads back as 1 until the conversion completes. The quotient is produced by a sequential restoring divider. The divider runs inside the conversion window and finishes well before the deadline.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After reset the control word and the result word both read 0, and `irq` is low.
- R2: The control word is at byte offset 0x0. Its fields are:
  - channel select in bits 27:24
  - interrupt enable in bit 21
  - reference select in bit 19
  - interrupt flag in bit 18
  - enable in bit 17
  - soft reset in bit 16 (always reads 0)
  - convert/busy in bit 14
  - divider DIV in bits 8:1

  All other control bits read 0. The result word is at offset 0x4, with the code in bits 9:0 and zeros above.
- R3: A conversion lasts exactly 20 × 2 × (DIV+1) clock cycles after the write that starts it. DIV is taken from that write. Bit 14 reads 1 for the whole interval and reads 0 from the cycle after the last one.
- R4: At completion the result becomes min(sample × 1024 / reference, 1023), using integer division.
  - A reference of 0 gives 1023.
  - Reference select bit 19 = 1 picks `refInternal`; bit 19 = 0 picks `refExternal`.
  - The sample, channel and reference are captured when the conversion starts.
- R5: At completion, if interrupt enable (bit 21) is set, the interrupt flag (bit 18) is set. `irq` always equals the flag, and it rises only on a completion.
- R6: Writing 1 to bit 18 clears the flag and lowers `irq`. Writing 0 leaves the flag unchanged, and the flag holds while no control write occurs.
- R7: A conversion starts only on a control write that has bit 17 = 1 and bit 14 = 1 while no conversion is running. A further write with bit 14 = 1 during a conversion does not restart or extend it.
- R8: A control write with bit 17 = 0 cancels any running conversion, and bit 14 then reads 0. The result and the flag are untouched, and no completion follows.
- R9: A control write with bit 16 = 1 returns the control word, the result and `irq` to their reset values and stops any running conversion.
- R10: If the captured channel is 8 or higher, completion leaves the result unchanged. Bit 14 still clears, and the flag still follows R5.
- R11: Writes to offset 0x4 or to any other offset have no effect. Reads of unmapped offsets return 0, and `busRdData` is 0 while `busRdEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read enable; gates `busRdData` |
| busAddr | input | ADDR_W (12) | Byte offset of the access |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data (combinational) |
| chanSamples | input | NUM_CH × SAMPLE_W (192) | Digital samples; channel k in bits k×SAMPLE_W upward |
| refInternal | input | SAMPLE_W (24) | Internal reference value |
| refExternal | input | SAMPLE_W (24) | External reference value |
| irq | output | 1 | Level interrupt, equal to the flag bit |

## Verification
The bound checker watches the interrupt flag on every cycle:
- it rises only on a completion strobe;
- it stays set without a control write;
- it drops after a write-1 clear and after a soft reset.

The checker also confirms that the divider is idle whenever a completion fires, that busy clears on completion and on cancel, and that the result never moves except on completion or soft reset. Only the bench scenarios can show the exact conversion length for several divider values, the arithmetic with saturation and a zero reference, and the capture of the sample and reference at start while inputs change. Those scenarios also cover restart immunity, the unmapped-channel case, and the ignored writes and zero reads at unused offsets.

// File: rtl/adc_conv_pkg.sv
package adc_conv_pkg;
  // Register offsets (byte addresses)
  localparam int CTL_OFS = 'h0;
  localparam int RES_OFS = 'h4;

  // Control word bit positions
  localparam int CHAN_LSB   = 24;
  localparam int INTEN_BIT  = 21;
  localparam int REFSEL_BIT = 19;
  localparam int FLAG_BIT   = 18;
  localparam int EN_BIT     = 17;
  localparam int SRST_BIT   = 16;
  localparam int BUSY_BIT   = 14;
  localparam int DIV_LSB    = 1;

  // Prescaled ticks per conversion
  localparam int TICKS_PER_CONV = 20;

  // Strobes from control to datapath
  typedef struct packed {
    logic start;
    logic finish;
    logic swReset;
  } ctlStrobe_t;
endpackage

// File: rtl/adc_conv_control.sv
module adc_conv_control
  import adc_conv_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int CHSEL_W = 4,
  parameter int TICKS   = TICKS_PER_CONV
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctlWr,
  input  logic [31:0]        wrData,
  output ctlStrobe_t         stb,
  output logic [CHSEL_W-1:0] nextChan,
  output logic               nextRefSel,
  output logic [31:0]        ctlWord
);
  localparam int TICK_W = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam int PRE_W  = DIV_W + 1;
  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(TICKS - 1);

  logic [CHSEL_W-1:0] chanQ;
  logic               intEnQ, refSelQ, flagQ, enQ, busyQ;
  logic [DIV_W-1:0]   divQ, divLatQ;
  logic [PRE_W-1:0]   preCnt, preLimit;
  logic [TICK_W-1:0]  tickCnt;

  logic srst, cancel, lastTick, finish, start;

  // prescaler limit 2*(DIV+1)-1 = 2*DIV+1
  assign preLimit = {divLatQ, 1'b1};

  always_comb begin
    srst     = ctlWr && wrData[SRST_BIT];
    cancel   = ctlWr && !wrData[SRST_BIT] && !wrData[EN_BIT];
    lastTick = (preCnt == preLimit) && (tickCnt == LAST_TICK);
    finish   = busyQ && lastTick && !srst && !cancel;
    start    = ctlWr && !srst && wrData[EN_BIT] && wrData[BUSY_BIT] && !busyQ;
    stb.start   = start;
    stb.finish  = finish;
    stb.swReset = srst;
    nextChan    = wrData[CHAN_LSB +: CHSEL_W];
    nextRefSel  = wrData[REFSEL_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanQ   <= '0;
      intEnQ  <= 1'b0;
      refSelQ <= 1'b0;
      flagQ   <= 1'b0;
      enQ     <= 1'b0;
      busyQ   <= 1'b0;
      divQ    <= '0;
      divLatQ <= '0;
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (srst) begin
      chanQ   <= '0;
      intEnQ  <= 1'b0;
      refSelQ <= 1'b0;
      flagQ   <= 1'b0;
      enQ     <= 1'b0;
      busyQ   <= 1'b0;
      divQ    <= '0;
      divLatQ <= '0;
      preCnt  <= '0;
      tickCnt <= '0;
    end else begin
      if (ctlWr) begin
        chanQ   <= wrData[CHAN_LSB +: CHSEL_W];
        intEnQ  <= wrData[INTEN_BIT];
        refSelQ <= wrData[REFSEL_BIT];
        enQ     <= wrData[EN_BIT];
        divQ    <= wrData[DIV_LSB +: DIV_W];
      end
      // completion sets the flag; write-1 clears it
      flagQ <= (flagQ && !(ctlWr && wrData[FLAG_BIT])) || (finish && intEnQ);
      if (cancel || finish) begin
        busyQ <= 1'b0;
      end else if (start) begin
        busyQ   <= 1'b1;
        divLatQ <= wrData[DIV_LSB +: DIV_W];
        preCnt  <= '0;
        tickCnt <= '0;
      end else if (busyQ) begin
        if (preCnt == preLimit) begin
          preCnt  <= '0;
          tickCnt <= tickCnt + 1'b1;
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    ctlWord = '0;
    ctlWord[CHAN_LSB +: CHSEL_W] = chanQ;
    ctlWord[INTEN_BIT]           = intEnQ;
    ctlWord[REFSEL_BIT]          = refSelQ;
    ctlWord[FLAG_BIT]            = flagQ;
    ctlWord[EN_BIT]              = enQ;
    ctlWord[BUSY_BIT]            = busyQ;
    ctlWord[DIV_LSB +: DIV_W]    = divQ;
  end
endmodule

// File: rtl/adc_conv_datapath.sv
module adc_conv_datapath
  import adc_conv_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int SAMPLE_W = 24,
  parameter int RES_W    = 10,
  parameter int CHSEL_W  = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctlStrobe_t                 stb,
  input  logic [CHSEL_W-1:0]         nextChan,
  input  logic                       nextRefSel,
  input  logic [NUM_CH*SAMPLE_W-1:0] chanFlat,
  input  logic [SAMPLE_W-1:0]        refInt,
  input  logic [SAMPLE_W-1:0]        refExt,
  output logic [RES_W-1:0]           result,
  output logic                       divIdle
);
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int NUM_W = SAMPLE_W + RES_W;
  localparam int REM_W = SAMPLE_W + 1;
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [SAMPLE_W-1:0] chanArr [NUM_CH];

  for (genvar k = 0; k < NUM_CH; k++) begin : g_unpack
    assign chanArr[k] = chanFlat[k*SAMPLE_W +: SAMPLE_W];
  end

  logic                chanOk;
  logic [SAMPLE_W-1:0] selSample, selRef;

  always_comb begin
    chanOk    = int'(nextChan) < NUM_CH;
    selSample = chanOk ? chanArr[nextChan[IDX_W-1:0]] : '0;
    selRef    = nextRefSel ? refInt : refExt;
  end

  logic [NUM_W-1:0]    quoQ;
  logic [REM_W-1:0]    remQ;
  logic [SAMPLE_W-1:0] denQ;
  logic [CNT_W-1:0]    cntQ;
  logic                chanOkQ;
  logic [RES_W-1:0]    resultQ;

  // One restoring step per cycle
  logic [REM_W-1:0] remShift, remNext;
  logic             geq;
  logic [NUM_W-1:0] quoNext;
  logic             overflow;
  logic [RES_W-1:0] satCode;

  always_comb begin
    remShift = {remQ[REM_W-2:0], quoQ[NUM_W-1]};
    geq      = remShift >= {1'b0, denQ};
    remNext  = geq ? (remShift - {1'b0, denQ}) : remShift;
    quoNext  = {quoQ[NUM_W-2:0], geq};
    overflow = |quoQ[NUM_W-1:RES_W];
    satCode  = overflow ? '1 : quoQ[RES_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quoQ    <= '0;
      remQ    <= '0;
      denQ    <= '0;
      cntQ    <= '0;
      chanOkQ <= 1'b0;
      resultQ <= '0;
    end else if (stb.swReset) begin
      cntQ    <= '0;
      chanOkQ <= 1'b0;
      resultQ <= '0;
    end else begin
      if (stb.start) begin
        quoQ    <= {selSample, {RES_W{1'b0}}};
        remQ    <= '0;
        denQ    <= selRef;
        cntQ    <= CNT_W'(NUM_W);
        chanOkQ <= chanOk;
      end else if (cntQ != '0) begin
        quoQ <= quoNext;
        remQ <= remNext;
        cntQ <= cntQ - 1'b1;
      end
      if (stb.finish && chanOkQ) resultQ <= satCode;
    end
  end

  assign result  = resultQ;
  assign divIdle = (cntQ == '0);
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_conv_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int SAMPLE_W = 24,
  parameter int DIV_W    = 8,
  parameter int ADDR_W   = 12
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busWrEn,
  input  logic                       busRdEn,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [31:0]                busWrData,
  output logic [31:0]                busRdData,
  input  logic [NUM_CH*SAMPLE_W-1:0] chanSamples,
  input  logic [SAMPLE_W-1:0]        refInternal,
  input  logic [SAMPLE_W-1:0]        refExternal,
  output logic                       irq
);
  localparam int RES_W   = 10;
  localparam int CHSEL_W = 4;

  ctlStrobe_t         ctlStb;
  logic [CHSEL_W-1:0] nextChan;
  logic               nextRefSel;
  logic [31:0]        ctlWord;
  logic [RES_W-1:0]   resultVal;
  logic               divIdle;
  logic               ctlWr;

  assign ctlWr = busWrEn && (busAddr == ADDR_W'(CTL_OFS));

  adc_conv_control #(
    .DIV_W(DIV_W), .CHSEL_W(CHSEL_W), .TICKS(TICKS_PER_CONV)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .ctlWr(ctlWr), .wrData(busWrData),
    .stb(ctlStb), .nextChan(nextChan), .nextRefSel(nextRefSel),
    .ctlWord(ctlWord)
  );

  adc_conv_datapath #(
    .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .RES_W(RES_W), .CHSEL_W(CHSEL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(ctlStb), .nextChan(nextChan),
    .nextRefSel(nextRefSel), .chanFlat(chanSamples), .refInt(refInternal),
    .refExt(refExternal), .result(resultVal), .divIdle(divIdle)
  );

  always_comb begin
    busRdData = '0;
    if (busRdEn) begin
      if (busAddr == ADDR_W'(CTL_OFS))      busRdData = ctlWord;
      else if (busAddr == ADDR_W'(RES_OFS)) busRdData = {{(32-RES_W){1'b0}}, resultVal};
    end
  end

  assign irq = ctlWord[FLAG_BIT];
endmodule

// File: rtl/adc_conv_checker.sv
module adc_conv_checker (
  input logic        clk,
  input logic        rstN,
  input logic        ctlWr,
  input logic [31:0] wrData,
  input logic        irq,
  input logic        finishStb,
  input logic        swResetStb,
  input logic        divIdle,
  input logic        busyBit,
  input logic [9:0]  result
);
  // R9: soft reset drops irq and clears the result
  p_swreset_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    swResetStb |=> (!irq && result == 10'd0));

  // R6: write-1 clears the flag
  p_w1c_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && wrData[18] && !finishStb) |=> !irq);

  // R6: the flag holds without a control write
  p_flag_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !ctlWr) |=> irq);

  // R5: irq rises only after a completion
  p_irq_source_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(finishStb));

  // R4: the divider has finished when the timer expires
  p_div_ahead_r4: assert property (@(posedge clk) disable iff (!rstN)
    finishStb |-> divIdle);

  // R3: busy clears on completion
  p_busy_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    finishStb |=> !busyBit);

  // R8: disabling cancels
  p_cancel_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && !wrData[16] && !wrData[17]) |=> !busyBit);

  // R8: the result only moves on completion or soft reset
  p_result_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!finishStb && !swResetStb) |=> $stable(result));
endmodule

bind adc_conv_ctrl adc_conv_checker u_chk (
  .clk(clk), .rstN(rstN), .ctlWr(ctlWr), .wrData(busWrData), .irq(irq),
  .finishStb(ctlStb.finish), .swResetStb(ctlStb.swReset), .divIdle(divIdle),
  .busyBit(ctlWord[14]), .result(resultVal)
);

// File: tb/sim_adc_conv_ctrl.sv
`timescale 1ns/1ps
module sim_adc_conv_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [191:0] chanFlat;
  logic [23:0] smp [8];
  logic [23:0] refInt = 24'd2000000, refExt = 24'd1000000;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  always_comb for (int i = 0; i < 8; i++) chanFlat[i*24 +: 24] = smp[i];

  adc_conv_ctrl u0 (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .chanSamples(chanFlat), .refInternal(refInt), .refExternal(refExt),
    .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  int mChan, mDiv, mLeft, mResult, lChan;
  bit mIntEn, mRefSel, mFlag, mEn, mBusy;
  longint lIn, lRef;

  function automatic int calc(longint a, longint r);
    longint q;
    if (r == 0) return 1023;
    q = (a * 1024) / r;
    return (q > 1023) ? 1023 : int'(q);
  endfunction

  always @(posedge clk) begin
    bit wr, cancel, fin, newFlag;
    if (!rstN) begin
      mChan = 0; mDiv = 0; mLeft = 0; mResult = 0; lChan = 0;
      mIntEn = 0; mRefSel = 0; mFlag = 0; mEn = 0; mBusy = 0;
    end else begin
      wr = busWrEn && busAddr == 12'h0;
      if (wr && busWrData[16]) begin
        mChan = 0; mDiv = 0; mLeft = 0; mResult = 0;
        mIntEn = 0; mRefSel = 0; mFlag = 0; mEn = 0; mBusy = 0;
      end else begin
        cancel = wr && !busWrData[17];
        fin = mBusy && mLeft == 1 && !cancel;
        if (fin && lChan < 8) mResult = calc(lIn, lRef);
        newFlag = (mFlag && !(wr && busWrData[18])) || (fin && mIntEn);
        if (wr) begin
          mChan = int'(busWrData[27:24]); mIntEn = busWrData[21];
          mRefSel = busWrData[19]; mEn = busWrData[17];
          mDiv = int'(busWrData[8:1]);
        end
        if (cancel || fin) mBusy = 0;
        else if (mBusy) mLeft--;
        else if (wr && busWrData[17] && busWrData[14]) begin
          mBusy = 1; mLeft = 40 * (mDiv + 1); lChan = mChan;
          lIn = (lChan < 8) ? longint'(smp[lChan]) : 0;
          lRef = mRefSel ? longint'(refInt) : longint'(refExt);
        end
        mFlag = newFlag;
      end
    end
  end

  // per-cycle comparison of the interrupt line (R5, R6)
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (irq !== mFlag) begin
        errors++;
        $display("FAIL R5/R6 irq per-cycle at %0t: got %0b exp %0b", $time, irq, mFlag);
      end
    end
  end

  // ---------------- helpers ----------------
  function automatic logic [31:0] cw(int chan, bit ie, bit rs, bit fl, bit en,
                                     bit sr, bit cv, int dv);
    logic [31:0] v = '0;
    v[27:24] = chan[3:0]; v[21] = ie; v[19] = rs; v[18] = fl;
    v[17] = en; v[16] = sr; v[14] = cv; v[8:1] = dv[7:0];
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h exp 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, bit en, logic [31:0] exp, string tag);
    busAddr = a; busRdEn = en;
    #1;
    chk(tag, busRdData, exp);
    busRdEn = 1'b0;
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    smp[0] = 24'd100000; smp[1] = 24'd300000; smp[2] = 24'd500000;
    smp[3] = 24'd3000000;
    for (int i = 4; i < 8; i++) smp[i] = 24'(i * 50000);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(12'h0, 1, 32'h0, "R1 control after reset");
    rd(12'h4, 1, 32'h0, "R1 result after reset");
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);

    // R3/R4/R5 basic conversion, DIV=0 -> 40 cycles, 500000*1024/2000000=256
    wr(12'h0, cw(2,1,1,0,1,0,1,0));
    waitN(39);
    rd(12'h0, 1, cw(2,1,1,0,1,0,1,0), "R3 busy at last cycle DIV=0");
    waitN(1);
    rd(12'h0, 1, cw(2,1,1,1,1,0,0,0), "R2 R5 control after completion");
    rd(12'h4, 1, 32'd256, "R4 result internal ref");
    chk("R5 irq after completion", {31'b0, irq}, 32'h1);

    // R6 write 0 keeps flag, write 1 clears
    wr(12'h0, cw(2,1,1,0,1,0,0,0));
    chk("R6 flag kept on write 0", {31'b0, irq}, 32'h1);
    wr(12'h0, cw(2,1,1,1,1,0,0,0));
    chk("R6 flag cleared on write 1", {31'b0, irq}, 32'h0);

    // R4 external reference, R5 no interrupt when disabled
    wr(12'h0, cw(1,0,0,0,1,0,1,0));
    waitN(40);
    rd(12'h4, 1, 32'd307, "R4 result external ref");
    chk("R5 no irq with enable clear", {31'b0, irq}, 32'h0);

    // R4 saturation
    wr(12'h0, cw(3,0,1,0,1,0,1,0));
    waitN(40);
    rd(12'h4, 1, 32'd1023, "R4 saturation");

    // R3 DIV=3 -> 160 cycles
    wr(12'h0, cw(0,0,1,0,1,0,1,3));
    waitN(159);
    rd(12'h0, 1, cw(0,0,1,0,1,0,1,3), "R3 busy at last cycle DIV=3");
    waitN(1);
    rd(12'h0, 1, cw(0,0,1,0,1,0,0,3), "R3 busy clear DIV=3");
    rd(12'h4, 1, 32'd51, "R4 result DIV=3");

    // R7 no restart, R4 sample captured at start; DIV=1 -> 80 cycles
    wr(12'h0, cw(2,1,1,0,1,0,1,1));
    smp[2] = 24'd40000;
    waitN(30);
    wr(12'h0, cw(2,1,1,0,1,0,1,1));
    waitN(47);
    rd(12'h0, 1, cw(2,1,1,0,1,0,1,1), "R7 still busy at original end-1");
    waitN(1);
    rd(12'h0, 1, cw(2,1,1,1,1,0,0,1), "R7 completes at original time");
    rd(12'h4, 1, 32'd256, "R4 sample captured at start");
    smp[2] = 24'd500000;
    wr(12'h0, cw(2,0,1,1,1,0,0,0));

    // R8 cancel
    wr(12'h0, cw(0,1,1,0,1,0,1,0));
    waitN(10);
    wr(12'h0, cw(0,1,1,0,0,0,1,0));
    rd(12'h0, 1, cw(0,1,1,0,0,0,0,0), "R8 busy reads 0 after cancel");
    waitN(60);
    chk("R8 no irq after cancel", {31'b0, irq}, 32'h0);
    rd(12'h4, 1, 32'd256, "R8 result untouched by cancel");

    // R10 unmapped channel
    wr(12'h0, cw(9,1,1,0,1,0,1,0));
    waitN(40);
    rd(12'h0, 1, cw(9,1,1,1,1,0,0,0), "R10 busy clear, flag set");
    rd(12'h4, 1, 32'd256, "R10 result unchanged");
    wr(12'h0, cw(9,0,1,1,1,0,0,0));

    // R4 zero reference
    refExt = 24'd0;
    wr(12'h0, cw(1,0,0,0,1,0,1,0));
    waitN(40);
    rd(12'h4, 1, 32'd1023, "R4 zero reference");
    refExt = 24'd1000000;

    // R11 ignored writes and zero reads
    wr(12'h4, 32'h0);
    rd(12'h4, 1, 32'd1023, "R11 result write ignored");
    wr(12'h8, cw(0,0,0,0,0,1,0,0));
    rd(12'h0, 1, cw(1,0,0,0,1,0,0,0), "R11 unmapped write ignored");
    rd(12'h8, 1, 32'h0, "R11 unmapped read");
    rd(12'h0, 0, 32'h0, "R11 read data without enable");

    // R9 soft reset during conversion
    wr(12'h0, cw(2,1,1,0,1,0,1,0));
    waitN(40);
    chk("R9 precondition irq", {31'b0, irq}, 32'h1);
    wr(12'h0, cw(2,1,1,0,1,0,1,0));
    chk("R7 rewrite does not clear flag", {31'b0, irq}, 32'h1);
    wr(12'h0, cw(2,0,1,1,1,0,0,0));
    wr(12'h0, cw(2,1,1,0,1,0,1,0));
    waitN(5);
    wr(12'h0, cw(5,1,1,0,1,1,1,7));
    rd(12'h0, 1, 32'h0, "R9 control after soft reset");
    rd(12'h4, 1, 32'h0, "R9 result after soft reset");
    waitN(50);
    chk("R9 no completion after soft reset", {31'b0, irq}, 32'h0);
    rd(12'h0, 1, 32'h0, "R9 stays idle");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule